// File: doc/BRIEF.md
# Multiplexed-Bus PSRAM Burst Sequencer

This block is the device side of a pseudo-static RAM that shares its lower address lines with its data lines. A bus master opens an access by holding chip enable low and pulsing the address-valid strobe low for one clock. The upper address bits come from their own pins and the lower bits from the shared lines. The level of write enable at that edge picks a read or a write. The sequencer then counts a configurable initial latency and steps a word address once per clock. Each step feeds an internal array port that carries address, write strobe, per-byte enables and data.

Two address orders are offered. In windowed mode the address wraps inside an aligned window of 4, 8, 16 or 32 words. In continuous mode the address runs forward without limit, rolls over from the top of memory to zero, and pauses for a fixed number of cycles at every row crossing while the next row opens. The WAIT output flags every cycle in which no data can move, and its polarity is selectable.

The shared bus appears as separate inbound and outbound vectors plus an output-enable flag, so the block can act as a target model in a controller testbench. Configuration inputs are meant to be held steady while chip enable is low.

Top module: `psram_burst_seq`

## Requirements
- R1: On a rising clock edge with `ce_n` low and `adv_n` low, the start address `{a_hi, adq_in}` is captured, and `we_n` at that edge selects a write (0) or a read (1). The first data cycle uses exactly that address on `arr_addr`.
- R2: Let L be `cfg_latency`, with a code of 0 treated as 1. The first data word moves on the (L+1)-th rising edge after the address edge, so code 2 gives the third edge. On a read, `adq_oe` is high and `adq_out` equals `arr_rdata` at the current address during each data cycle.
- R3: WAIT is active in every cycle from the address edge until the first data cycle, and inactive in data cycles and while `ce_n` is high. `wait_o` equals `cfg_wait_pol` when active and its inverse when inactive, so a value of 0 gives active-low WAIT.
- R4: With `cfg_cont`=0 the window length is 4 shifted left by `cfg_len_code` (0:4, 1:8, 2:16, 3:32). The low log2(length) address bits count up modulo the length, and the upper bits stay fixed. No row-crossing WAIT is ever produced in this mode.
- R5: With `cfg_cont`=1 the address rises by one per data cycle and rolls over from all ones to zero.
- R6: With `cfg_cont`=1, a data cycle at an address whose low log2(ROW_WORDS) bits are all ones is followed by ROW_STALL cycles with WAIT active. Data then resumes at the next address.
- R7: `ce_n` high ends the burst at the next edge. Later cycles with `ce_n` low but no address strobe give no data and no WAIT until a new address cycle.
- R8: In a write data cycle, `arr_we` is high only if at least one of `lb_n` (bits 7:0) and `ub_n` (bits 15:8) is low. `arr_be[0]`=!`lb_n` and `arr_be[1]`=!`ub_n`. A cycle with both high leaves the array unchanged.
- R9: An address cycle during a burst aborts that burst and starts a new one from the new address and direction, with a fresh latency count.
- R10: While `rst_n` is low the block is idle: WAIT inactive, `adq_oe` low and `arr_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_latency | input | LAT_W | Initial latency code |
| cfg_len_code | input | 2 | Window length code for windowed mode |
| cfg_cont | input | 1 | 1 = continuous order, 0 = windowed |
| cfg_wait_pol | input | 1 | Level of WAIT when active |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| we_n | input | 1 | Write select sampled in the address cycle |
| lb_n | input | 1 | Low byte enable, active low |
| ub_n | input | 1 | High byte enable, active low |
| a_hi | input | ADDR_W-DATA_W | Upper address bits |
| adq_in | input | DATA_W | Shared lines, inbound (low address or write data) |
| adq_out | output | DATA_W | Shared lines, outbound read data |
| adq_oe | output | 1 | Drive enable for `adq_out` |
| wait_o | output | 1 | WAIT flag at the selected polarity |
| arr_addr | output | ADDR_W | Array word address |
| arr_we | output | 1 | Array write strobe for this cycle |
| arr_be | output | DATA_W/8 | Array byte enables |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data for `arr_addr` |

## Verification
The embedded properties assume that the configuration inputs stay constant while `ce_n` is low. They also assume that ROW_WORDS is a power of two no smaller than the largest window. The stimulus changes configuration only in cycles with `ce_n` high and drives every input half a clock away from the sampling edge. Bursts use latency codes 0 through 5, windowed starts in the middle of a window, continuous runs that cross a row and the top of memory, early aborts, and restarts with a new address strobe.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LAT   = 2'd1,
    PH_DATA  = 2'd2,
    PH_STALL = 2'd3
  } phase_e;

  localparam int unsigned LEN_CODE_W = 2;

  // Window length in words for a windowed burst: 4, 8, 16 or 32.
  function automatic int unsigned burst_len(input logic [LEN_CODE_W-1:0] code);
    return 32'd4 << code;
  endfunction

endpackage

// File: rtl/psram_addr_ctr.sv
module psram_addr_ctr
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int ROW_WORDS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     load_addr,
  input  logic                  step,
  input  logic                  cfg_cont,
  input  logic [LEN_CODE_W-1:0] cfg_len_code,
  output logic [ADDR_W-1:0]     cur_addr,
  output logic                  cross_row
);

  localparam int ROW_LG = $clog2(ROW_WORDS);

  logic [ADDR_W-1:0] cur_q;

  function automatic logic [ADDR_W-1:0] win_mask(input logic [LEN_CODE_W-1:0] code);
    return ADDR_W'(burst_len(code) - 32'd1);
  endfunction

  // Windowed order: low bits count modulo the window, upper bits held.
  function automatic logic [ADDR_W-1:0] wrap_next(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_CODE_W-1:0] code);
    logic [ADDR_W-1:0] m;
    m = win_mask(code);
    return (a & ~m) | ((a + ADDR_W'(1)) & m);
  endfunction

  // Continuous order: plain increment, natural rollover at the top.
  function automatic logic [ADDR_W-1:0] lin_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic row_last(input logic [ADDR_W-1:0] a);
    return &a[ROW_LG-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load) begin
      cur_q <= load_addr;
    end else if (step) begin
      cur_q <= cfg_cont ? lin_next(cur_q) : wrap_next(cur_q, cfg_len_code);
    end
  end

  assign cur_addr  = cur_q;
  assign cross_row = cfg_cont && row_last(cur_q);

  // R1: the captured address is the one presented in the address cycle
  assert_load_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(load_addr)));

  // R5: continuous steps move up by exactly one, with rollover
  assert_cont_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cfg_cont) |=> (cur_q == $past(cur_q) + ADDR_W'(1)));

  // R4: windowed steps never leave the aligned window
  assert_wrap_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !cfg_cont && $stable(cfg_len_code)) |=>
      ((cur_q & ~win_mask(cfg_len_code)) == ($past(cur_q) & ~win_mask(cfg_len_code))));

endmodule

// File: rtl/psram_burst_fsm.sv
module psram_burst_fsm
  import psram_seq_pkg::*;
#(
  parameter int LAT_W     = 3,
  parameter int ROW_STALL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             we_n,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic             cross_row,
  output phase_e           phase,
  output logic             is_write,
  output logic             capture,
  output logic             beat
);

  localparam int STALL_W = $clog2(ROW_STALL + 2);
  localparam int CNT_W   = (LAT_W > STALL_W) ? LAT_W : STALL_W;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             stall_go;
  logic [CNT_W-1:0] lat_load;

  assign capture  = !ce_n && !adv_n;
  assign beat     = !ce_n && adv_n && (phase_q == PH_DATA);
  assign lat_load = (cfg_latency == '0) ? CNT_W'(1) : CNT_W'(cfg_latency);

  generate
    if (ROW_STALL > 0) begin : g_stall
      assign stall_go = beat && cross_row;

      // R6: a row crossing opens a stall window right after the beat
      assert_stall_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_go |=> (phase_q == PH_STALL));
    end else begin : g_nostall
      assign stall_go = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else if (ce_n) begin
      phase_q <= PH_IDLE;
    end else if (capture) begin
      phase_q <= PH_LAT;
      cnt_q   <= lat_load;
      wr_q    <= !we_n;
    end else begin
      unique case (phase_q)
        PH_LAT, PH_STALL: begin
          if (cnt_q == CNT_W'(1)) phase_q <= PH_DATA;
          else                    cnt_q   <= cnt_q - CNT_W'(1);
        end
        PH_DATA: begin
          if (stall_go) begin
            phase_q <= PH_STALL;
            cnt_q   <= CNT_W'(ROW_STALL);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = phase_q;
  assign is_write = wr_q;

  // R1: an address cycle always opens a latency phase
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (phase_q == PH_LAT));

  // R9: an address cycle in mid-burst restarts the latency count
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (phase_q == PH_DATA)) |=> ((phase_q == PH_LAT) && (cnt_q == lat_load)));

  // R2: the last latency cycle hands over to data
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_LAT) && !ce_n && adv_n && (cnt_q == CNT_W'(1))) |=> (phase_q == PH_DATA));

  // R2: a counting phase never holds a zero count
  assert_cnt_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_LAT) || (phase_q == PH_STALL)) |-> (cnt_q != '0));

  // R7: chip enable high ends everything at the next edge
  assert_ce_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/psram_bus_port.sv
module psram_bus_port
  import psram_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              is_write,
  input  logic              beat,
  input  logic              ce_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic              cfg_wait_pol,
  input  logic [DATA_W-1:0] adq_in,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] adq_out,
  output logic              adq_oe,
  output logic              wait_o,
  output logic              arr_we,
  output logic [DATA_W/8-1:0] arr_be,
  output logic [DATA_W-1:0] arr_wdata
);

  localparam int BE_W = DATA_W / 8;

  logic wait_act;

  // Lower half of the byte lanes follows lb_n, upper half follows ub_n.
  for (genvar b = 0; b < BE_W; b++) begin : g_be
    if (b < BE_W / 2) begin : g_lo
      assign arr_be[b] = !lb_n;
    end else begin : g_hi
      assign arr_be[b] = !ub_n;
    end
  end

  assign wait_act  = !ce_n && ((phase == PH_LAT) || (phase == PH_STALL));
  assign wait_o    = cfg_wait_pol ? wait_act : !wait_act;
  assign adq_oe    = beat && !is_write;
  assign adq_out   = adq_oe ? arr_rdata : '0;
  assign arr_we    = beat && is_write && (|arr_be);
  assign arr_wdata = adq_in;

  // R3: no data moves in a cycle that signals WAIT
  assert_wait_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o == cfg_wait_pol) |-> (!adq_oe && !arr_we));

  // R8: a fully masked cycle never writes the array
  assert_masked_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |-> !arr_we);

endmodule

// File: rtl/psram_burst_seq.sv
module psram_burst_seq
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int LAT_W     = 3,
  parameter int ROW_WORDS = 128,
  parameter int ROW_STALL = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LAT_W-1:0]         cfg_latency,
  input  logic [LEN_CODE_W-1:0]    cfg_len_code,
  input  logic                     cfg_cont,
  input  logic                     cfg_wait_pol,
  input  logic                     ce_n,
  input  logic                     adv_n,
  input  logic                     we_n,
  input  logic                     lb_n,
  input  logic                     ub_n,
  input  logic [ADDR_W-DATA_W-1:0] a_hi,
  input  logic [DATA_W-1:0]        adq_in,
  output logic [DATA_W-1:0]        adq_out,
  output logic                     adq_oe,
  output logic                     wait_o,
  output logic [ADDR_W-1:0]        arr_addr,
  output logic                     arr_we,
  output logic [DATA_W/8-1:0]      arr_be,
  output logic [DATA_W-1:0]        arr_wdata,
  input  logic [DATA_W-1:0]        arr_rdata
);

  phase_e            phase;
  logic              is_write;
  logic              capture;
  logic              beat;
  logic              cross_row;
  logic [ADDR_W-1:0] start_addr;

  assign start_addr = {a_hi, adq_in};

  psram_burst_fsm #(
    .LAT_W     (LAT_W),
    .ROW_STALL (ROW_STALL)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .adv_n       (adv_n),
    .we_n        (we_n),
    .cfg_latency (cfg_latency),
    .cross_row   (cross_row),
    .phase       (phase),
    .is_write    (is_write),
    .capture     (capture),
    .beat        (beat)
  );

  psram_addr_ctr #(
    .ADDR_W    (ADDR_W),
    .ROW_WORDS (ROW_WORDS)
  ) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (capture),
    .load_addr    (start_addr),
    .step         (beat),
    .cfg_cont     (cfg_cont),
    .cfg_len_code (cfg_len_code),
    .cur_addr     (arr_addr),
    .cross_row    (cross_row)
  );

  psram_bus_port #(
    .DATA_W (DATA_W)
  ) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .is_write     (is_write),
    .beat         (beat),
    .ce_n         (ce_n),
    .lb_n         (lb_n),
    .ub_n         (ub_n),
    .cfg_wait_pol (cfg_wait_pol),
    .adq_in       (adq_in),
    .arr_rdata    (arr_rdata),
    .adq_out      (adq_out),
    .adq_oe       (adq_oe),
    .wait_o       (wait_o),
    .arr_we       (arr_we),
    .arr_be       (arr_be),
    .arr_wdata    (arr_wdata)
  );

endmodule

// File: tb/psram_burst_seq_bench.sv
module psram_burst_seq_bench;

  localparam int AW    = 22;
  localparam int DW    = 16;
  localparam int LW    = 3;
  localparam int ROWW  = 128;
  localparam int STALL = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] cfg_latency;
  logic [1:0]    cfg_len_code;
  logic          cfg_cont, cfg_wait_pol;
  logic          ce_n, adv_n, we_n, lb_n, ub_n;
  logic [AW-DW-1:0] a_hi;
  logic [DW-1:0] adq_in, adq_out, arr_wdata, arr_rdata;
  logic          adq_oe, wait_o, arr_we;
  logic [AW-1:0] arr_addr;
  logic [1:0]    arr_be;

  always #4 clk = ~clk;

  psram_burst_seq #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW), .ROW_WORDS(ROWW), .ROW_STALL(STALL))
  u_psram_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_len_code(cfg_len_code),
    .cfg_cont(cfg_cont), .cfg_wait_pol(cfg_wait_pol), .ce_n(ce_n), .adv_n(adv_n),
    .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .a_hi(a_hi), .adq_in(adq_in),
    .adq_out(adq_out), .adq_oe(adq_oe), .wait_o(wait_o), .arr_addr(arr_addr),
    .arr_we(arr_we), .arr_be(arr_be), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R10";

  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];

  // reference model state: 0 idle, 1 latency, 2 data, 3 row stall
  int m_ph   = 0;
  int m_cnt  = 0;
  int m_addr = 0;
  bit m_wr   = 0;

  function automatic logic [15:0] seed_word(int a);
    return 16'(a * 7) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] dev_rd(int a);
    return dev_mem.exists(a) ? dev_mem[a] : seed_word(a);
  endfunction

  function automatic logic [15:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic model_step();
    logic [15:0] w;
    int len;
    bit crossed;
    if (!rst_n || ce_n) begin
      m_ph = 0;
    end else if (!adv_n) begin
      m_addr = int'({a_hi, adq_in});
      m_wr   = !we_n;
      m_ph   = 1;
      m_cnt  = (cfg_latency == 0) ? 1 : int'(cfg_latency);
    end else if (m_ph == 1 || m_ph == 3) begin
      if (m_cnt == 1) m_ph = 2;
      else m_cnt--;
    end else if (m_ph == 2) begin
      if (m_wr) begin
        w = ref_rd(m_addr);
        if (!lb_n) w[7:0]  = adq_in[7:0];
        if (!ub_n) w[15:8] = adq_in[15:8];
        ref_mem[m_addr] = w;
      end
      if (cfg_cont) begin
        crossed = ((m_addr + 1) % ROWW) == 0;
        m_addr  = (m_addr + 1) % (1 << AW);
        if (crossed) begin m_ph = 3; m_cnt = STALL; end
      end else begin
        len    = 4 << cfg_len_code;
        m_addr = (m_addr / len) * len + ((m_addr % len) + 1) % len;
      end
    end
  endtask

  // One cycle: outputs are compared in the low clock phase, the device
  // array takes the write strobe, the model advances, then on to the next low phase.
  task automatic cyc();
    bit exp_beat, exp_act, exp_we;
    string mode;
    #1;
    arr_rdata = dev_rd(int'(arr_addr));
    #1;
    exp_beat = rst_n && !ce_n && adv_n && (m_ph == 2);
    exp_act  = rst_n && !ce_n && (m_ph == 1 || m_ph == 3);
    exp_we   = exp_beat && m_wr && !(lb_n && ub_n);
    mode     = cfg_cont ? "R5 addr" : "R4 addr";
    chk(wait_o === (cfg_wait_pol ? exp_act : !exp_act),
        (m_ph == 3) ? "R6 wait" : "R3 wait", 32'(wait_o), 32'(cfg_wait_pol ? exp_act : !exp_act));
    chk(adq_oe === (exp_beat && !m_wr), "R2 oe", 32'(adq_oe), 32'(exp_beat && !m_wr));
    chk(arr_we === exp_we, "R8 we", 32'(arr_we), 32'(exp_we));
    if (exp_beat) chk(arr_addr === AW'(m_addr), mode, 32'(arr_addr), 32'(m_addr));
    if (exp_beat && !m_wr) chk(adq_out === ref_rd(m_addr), "R2 data", 32'(adq_out), 32'(ref_rd(m_addr)));
    if (arr_we) begin
      dev_mem[int'(arr_addr)] = (dev_rd(int'(arr_addr)) & ~{{8{arr_be[1]}}, {8{arr_be[0]}}})
                              | (arr_wdata & {{8{arr_be[1]}}, {8{arr_be[0]}}});
    end
    model_step();
    @(negedge clk);
  endtask

  task automatic drive(bit ce, bit adv, bit we, bit lb, bit ub, logic [21:0] v);
    ce_n = ce; adv_n = adv; we_n = we; lb_n = lb; ub_n = ub;
    a_hi = v[21:16]; adq_in = v[15:0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      drive(1, 1, 1, 1, 1, 22'h0);
      cyc();
    end
  endtask

  // Address cycle then n cycles with the strobe high; write data and byte
  // masks rotate through both, low only, high only, none.
  task automatic run(int addr, bit wr, int n);
    drive(0, 0, !wr, 1, 1, 22'(addr));
    cyc();
    for (int i = 0; i < n; i++) begin
      drive(0, 1, !wr, (i % 4 == 2) || (i % 4 == 3), (i % 4 == 1) || (i % 4 == 3),
            22'(16'(i * 16'h1357 + addr)));
      cyc();
    end
  endtask

  task automatic burst(int addr, bit wr, int n);
    run(addr, wr, n);
    idle(2);
  endtask

  initial begin
    #(8 * 150000);
    tag = "watchdog";
    chk(1'b0, "timeout", 32'd0, 32'd1);
    summary_and_end();
  end

  initial begin
    rst_n = 1'b0;
    cfg_latency = 3'd2; cfg_len_code = 2'd0; cfg_cont = 1'b0; cfg_wait_pol = 1'b0;
    drive(1, 1, 1, 1, 1, 22'h0);
    arr_rdata = '0;
    @(negedge clk);
    tag = "R10";                        // reset: idle outputs
    for (int i = 0; i < 3; i++) cyc();
    ce_n = 1'b0; adv_n = 1'b0;          // strobes under reset are ignored
    cyc();
    rst_n = 1'b1;
    idle(2);

    tag = "R1";                         // write with latency 2, 4-word window
    burst(22'h2A123, 1'b1, 2 + 6);
    tag = "R2";                         // read back, first word on third edge
    burst(22'h2A120, 1'b0, 2 + 8);

    tag = "R8";                         // masked writes, 8-word window, latency 3
    cfg_latency = 3'd3; cfg_len_code = 2'd1;
    burst(22'h00107, 1'b1, 3 + 8);
    tag = "R4";
    cfg_latency = 3'd1;
    burst(22'h00100, 1'b0, 1 + 10);
    cfg_latency = 3'd4; cfg_len_code = 2'd3;
    burst(22'h1005D, 1'b0, 4 + 40);
    cfg_len_code = 2'd2;
    burst(22'h0ABCE, 1'b0, 4 + 20);

    tag = "R6";                         // continuous across a row
    cfg_cont = 1'b1; cfg_latency = 3'd2;
    burst(22'h0007C, 1'b0, 2 + 12);

    tag = "R5";                         // continuous over the top of memory
    burst(22'h3FFFFD, 1'b1, 2 + 8);
    burst(22'h3FFFFD, 1'b0, 2 + 10);

    tag = "R3";                         // active-high WAIT, long and zero latency codes
    cfg_wait_pol = 1'b1; cfg_latency = 3'd5;
    burst(22'h00300, 1'b0, 5 + 6);
    cfg_latency = 3'd0;
    burst(22'h00310, 1'b0, 1 + 4);
    cfg_wait_pol = 1'b0; cfg_latency = 3'd2;

    tag = "R7";                         // abort, then chip enable low without a strobe
    run(22'h00500, 1'b0, 4);
    idle(2);
    for (int i = 0; i < 3; i++) begin
      drive(0, 1, 1, 0, 0, 22'h00500);
      cyc();
    end
    idle(1);

    tag = "R9";                         // restart mid-burst as a write elsewhere
    run(22'h00600, 1'b0, 4);
    burst(22'h007F0, 1'b1, 2 + 6);
    cfg_cont = 1'b0; cfg_len_code = 2'd3;
    burst(22'h007F0, 1'b0, 2 + 8);

    summary_and_end();
  end

endmodule